// File: doc/BRIEF.md
# Flash Byte-Program Command Sequencer

This block sits behind a serial-slave byte receiver on a flash device model and turns one byte-program command into a single-byte update of an on-chip storage array. While chip select is held active, it counts the incoming bytes. The first byte must be the program opcode 0x02. The next three bytes form a 24-bit target address, high byte first, and the fifth byte is the data to store. Nothing happens until chip select is released. On that release, the frame is checked for exactly five bytes and the right opcode, and the write-enable latch and the protection flag are sampled. Only if every check passes does a self-timed program operation start.

The program operation reads the old byte and stores the bitwise AND of the old and new values, so a program can only clear bits. An erased location reads 0xFF, and the array powers up erased. During the operation `busy` stays high for a fixed number of clock cycles. When `busy` drops, a one-cycle `wel_clr` pulse tells the owner of the write-enable latch to clear it. The collected address is brought out on `frame_addr` so that an external protection decoder can return `addr_prot`. The write port of the array is also brought out, so that the surrounding logic and the bench can observe each store.

Top module: `flash_pgm_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, `busy`, `mem_we` and `wel_clr` are 0.
- R2: A frame is accepted when `cs_n` rises after exactly five strobed bytes: opcode 0x02, address bits 23..16, address bits 15..8, address bits 7..0, then data. On acceptance the array is written at address bits ADDR_W-1..0. Once the fourth byte has landed, `frame_addr` shows the full 24-bit address.
- R3: The stored value is the old byte AND the received data byte. A location that has never been programmed holds 0xFF.
- R4: If `wel` is 0 in the cycle `cs_n` rises, the frame causes no write and no `busy`.
- R5: If `addr_prot` is 1 in the cycle `cs_n` rises, the frame causes no write and no `busy`.
- R6: A frame with fewer or more than five bytes is discarded without effect.
- R7: A frame whose first byte is not 0x02 is discarded without effect.
- R8: `busy` rises in the cycle after the rising edge of `cs_n` and stays high for exactly BUSY_CYCLES cycles. `mem_we` pulses for exactly one cycle inside that window.
- R9: `wel_clr` is a single-cycle pulse in the first cycle after `busy` falls. It occurs once per accepted frame and never otherwise.
- R10: A frame that completes while `busy` is high is discarded.
- R11: Byte strobes while `cs_n` is high are not counted toward any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; its rising edge commits a frame |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received byte |
| wel | input | 1 | Write-enable latch state |
| addr_prot | input | 1 | Protection flag for `frame_addr`, from an external decoder |
| frame_addr | output | 24 | Address collected from the current or last frame |
| busy | output | 1 | Program operation in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data (old AND new) |

## Verification
The bench goes after frame-length boundaries. It sends frames of zero to seven bytes. A design that commits on a count of at least five, instead of exactly five, would write on overlong frames. It also sends wrong opcodes and cases where the write-enable latch is clear or the address is protected at the moment of commit, each of which must leave the array untouched. It programs the same addresses repeatedly with data that tries to set bits. A design that stores the new data instead of the AND would show those bits as 1. A second frame committed during `busy` must be dropped, or a second write and a stretched `busy` appear.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;
  localparam int          FRAME_BYTES = 5;
  localparam int          FRAME_ADDR_W = 24;
  localparam logic [7:0]  OP_PROGRAM  = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_MERGE,
    ST_HOLD
  } pgm_state_e;
endpackage

// File: rtl/pgm_frame_rx.sv
module pgm_frame_rx
  import flash_pgm_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_n,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_byte,
  output logic                    commit_req,
  output logic                    frame_ok,
  output logic [FRAME_ADDR_W-1:0] addr,
  output logic [7:0]              data
);
  localparam int CNT_W = $clog2(FRAME_BYTES + 2);
  localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(3);
  localparam logic [CNT_W-1:0] C_DATA     = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] C_FULL     = CNT_W'(FRAME_BYTES);
  localparam logic [CNT_W-1:0] C_OVER     = CNT_W'(FRAME_BYTES + 1);

  logic [CNT_W-1:0] cnt;
  logic             op_ok;
  logic             cs_q;

  // byte counter saturates one past a full frame so overlong frames are seen
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      cnt   <= '0;
      op_ok <= 1'b0;
      addr  <= '0;
      data  <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_n) begin
        cnt <= '0;
      end else if (rx_valid) begin
        if (cnt != C_OVER) cnt <= cnt + 1'b1;
        if (cnt == '0)
          op_ok <= (rx_byte == OP_PROGRAM);
        else if (cnt <= C_ADDR_END)
          addr <= {addr[FRAME_ADDR_W-9:0], rx_byte};
        else if (cnt == C_DATA)
          data <= rx_byte;
      end
    end
  end

  assign commit_req = cs_n & ~cs_q;
  assign frame_ok   = (cnt == C_FULL) & op_ok;
endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_req,
  input  logic              frame_ok,
  input  logic              wel,
  input  logic              prot,
  input  logic [ADDR_W-1:0] frm_addr,
  input  logic [7:0]        frm_data,
  input  logic [7:0]        rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] op_addr,
  output logic              busy,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  localparam int CNT_W = $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  pgm_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       op_data;
  logic             accept;

  assign accept = commit_req & frame_ok & wel & ~prot & (state == ST_IDLE);
  assign rd_en  = (state == ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      busy      <= 1'b0;
      wel_clr   <= 1'b0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      wel_clr <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_FETCH;
          busy    <= 1'b1;
          cnt     <= LOAD;
          op_addr <= frm_addr;
          op_data <= frm_data;
        end
        ST_FETCH: state <= ST_MERGE;
        ST_MERGE: begin
          mem_we    <= 1'b1;
          mem_wdata <= rd_data & op_data;
          state     <= ST_HOLD;
        end
        default: mem_we <= 1'b0;
      endcase
      // self-timed window, independent of the merge steps
      if (busy) begin
        if (cnt == '0) begin
          busy    <= 1'b0;
          wel_clr <= 1'b1;
          state   <= ST_IDLE;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  // power-up contents: fully erased
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              wel,
  input  logic              addr_prot,
  output logic [23:0]       frame_addr,
  output logic              busy,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic       commit_req;
  logic       frame_ok;
  logic [7:0] frm_data;
  logic [7:0] rd_data;
  logic       rd_en;

  pgm_frame_rx u_rx (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .commit_req (commit_req),
    .frame_ok   (frame_ok),
    .addr       (frame_addr),
    .data       (frm_data)
  );

  pgm_ctrl #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .commit_req (commit_req),
    .frame_ok   (frame_ok),
    .wel        (wel),
    .prot       (addr_prot),
    .frm_addr   (frame_addr[ADDR_W-1:0]),
    .frm_data   (frm_data),
    .rd_data    (rd_data),
    .rd_en      (rd_en),
    .op_addr    (mem_addr),
    .busy       (busy),
    .wel_clr    (wel_clr),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
  );

  flash_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .re    (rd_en),
    .raddr (mem_addr),
    .rdata (rd_data)
  );
endmodule

// File: rtl/flash_pgm_chk.sv
module flash_pgm_chk #(
  parameter int BUSY_CYCLES = 16
) (
  input logic clk,
  input logic rst,
  input logic wel,
  input logic addr_prot,
  input logic busy,
  input logic wel_clr,
  input logic mem_we
);
  logic rst_q = 1'b0;
  int   blen;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)       blen <= 0;
    else if (busy) blen <= blen + 1;
    else           blen <= 0;
  end

  // R1: outputs idle once reset has been applied
  always @(posedge clk) begin
    if (rst_q) begin
      p_reset_idle_r1: assert (!busy && !mem_we && !wel_clr);
    end
  end

  p_we_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  p_we_single_r8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_busy_len_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && blen != 0) |-> (blen == BUSY_CYCLES));

  p_clr_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> wel_clr);

  p_clr_only_at_fall_r9: assert property (@(posedge clk) disable iff (rst)
    wel_clr |-> (!busy && $past(busy)));

  p_need_wel_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  p_prot_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(addr_prot));
endmodule

bind flash_pgm_seq flash_pgm_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wel       (wel),
  .addr_prot (addr_prot),
  .busy      (busy),
  .wel_clr   (wel_clr),
  .mem_we    (mem_we)
);

// File: tb/sim_flash_pgm_seq.sv
`timescale 1ns/1ps
module sim_flash_pgm_seq;
  localparam int AW   = 8;
  localparam int BUSY = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          wel = 1'b0;
  logic          addr_prot = 1'b0;
  logic [23:0]   frame_addr;
  logic          busy, wel_clr, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int we_cnt, busy_cnt, clr_cnt;
  logic [AW-1:0] we_addr;
  logic [7:0]    we_data;
  logic [7:0]    model [1 << AW];

  always #4 clk = ~clk;

  flash_pgm_seq #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .wel(wel), .addr_prot(addr_prot), .frame_addr(frame_addr), .busy(busy),
    .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wel_clr) clr_cnt++;
    if (mem_we) begin
      we_cnt++;
      we_addr = mem_addr;
      we_data = mem_wdata;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit accepts(input logic [7:0] op, input int nb, input bit w, input bit p);
    return (op == 8'h02) && (nb == 5) && w && !p;
  endfunction

  function automatic string reason(input logic [7:0] op, input int nb, input bit w);
    if (nb != 5)      return "R6";
    if (op != 8'h02)  return "R7";
    if (!w)           return "R4";
    return "R5";
  endfunction

  task automatic clear_mon();
    we_cnt = 0; busy_cnt = 0; clr_cnt = 0;
  endtask

  task automatic send_frame(input logic [7:0] op, input int nb, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      case (i)
        0: rx_byte = op;
        1: rx_byte = a[23:16];
        2: rx_byte = a[15:8];
        3: rx_byte = a[7:0];
        4: rx_byte = d;
        default: rx_byte = 8'($urandom);
      endcase
      @(negedge clk) rx_valid = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
  endtask

  task automatic run_case(input logic [7:0] op, input int nb, input logic [23:0] a,
                          input logic [7:0] d, input bit w, input bit p);
    bit acc;
    string tag;
    logic [7:0] exp;
    acc = accepts(op, nb, w, p);
    tag = acc ? "R2" : reason(op, nb, w);
    clear_mon();
    wel = w;
    addr_prot = p;
    send_frame(op, nb, a, d);
    repeat (BUSY + 8) @(negedge clk);
    chk(tag, we_cnt == int'(acc), we_cnt, acc);
    chk("R8 busy length", busy_cnt == (acc ? BUSY : 0), busy_cnt, acc ? BUSY : 0);
    chk("R9 wel_clr pulses", clr_cnt == int'(acc), clr_cnt, acc);
    if (acc) begin
      exp = model[a[AW-1:0]] & d;
      chk("R3 stored value", we_data == exp, we_data, exp);
      chk("R2 write address", we_addr == a[AW-1:0], we_addr, a[AW-1:0]);
      model[a[AW-1:0]] = exp;
    end
    if (nb >= 4) chk("R2 frame_addr", frame_addr == a, frame_addr, a);
  endtask

  initial begin
    logic [7:0] x;
    void'($urandom(32'd20240607));
    for (int i = 0; i < (1 << AW); i++) model[i] = 8'hFF;
    clear_mon();
    repeat (4) @(negedge clk);
    chk("R1 busy", busy == 1'b0, busy, 0);
    chk("R1 mem_we", mem_we == 1'b0, mem_we, 0);
    chk("R1 wel_clr", wel_clr == 1'b0, wel_clr, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", !busy && !mem_we && !wel_clr, {busy, mem_we, wel_clr}, 0);

    // R3: fresh location, then an attempt to set cleared bits
    run_case(8'h02, 5, 24'h012355, 8'hA5, 1'b1, 1'b0);
    run_case(8'h02, 5, 24'h012355, 8'h5F, 1'b1, 1'b0);
    // R6 boundaries: four and six bytes
    run_case(8'h02, 4, 24'h000011, 8'h00, 1'b1, 1'b0);
    run_case(8'h02, 6, 24'h000011, 8'h00, 1'b1, 1'b0);
    // R7, R4, R5 directed
    run_case(8'h03, 5, 24'h000022, 8'h00, 1'b1, 1'b0);
    run_case(8'h02, 5, 24'h000022, 8'h00, 1'b0, 1'b0);
    run_case(8'h02, 5, 24'h800022, 8'h00, 1'b1, 1'b1);

    // R10: second frame committed during busy is dropped
    clear_mon();
    wel = 1'b1; addr_prot = 1'b0;
    send_frame(8'h02, 5, 24'h000033, 8'hC3);
    send_frame(8'h02, 5, 24'h000044, 8'h00);
    repeat (BUSY + 8) @(negedge clk);
    chk("R10 write count", we_cnt == 1, we_cnt, 1);
    chk("R10 busy length", busy_cnt == BUSY, busy_cnt, BUSY);
    chk("R10 data of first frame", we_data == 8'hC3, we_data, 8'hC3);
    model[8'h33] = 8'hC3;

    // R11: strobes while deselected, then a normal frame
    clear_mon();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) begin rx_valid = 1'b1; rx_byte = 8'h02; end
      @(negedge clk) rx_valid = 1'b0;
    end
    send_frame(8'h02, 5, 24'h000066, 8'h3C);
    repeat (BUSY + 8) @(negedge clk);
    chk("R11 stray strobes ignored", we_cnt == 1, we_cnt, 1);
    model[8'h66] = 8'h3C;

    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      logic [7:0]  op;
      int          nb;
      logic [23:0] a;
      bit          w, p;
      op = ($urandom % 8 == 0) ? 8'($urandom) : 8'h02;
      nb = ($urandom % 4 == 0) ? int'($urandom % 8) : 5;
      x  = 8'(($urandom % 8) * 8'h21);
      a  = {8'($urandom), 8'($urandom), x};
      a[23] = ($urandom % 6 == 0);
      w  = ($urandom % 5 != 0);
      p  = a[23];
      run_case(op, nb, a, 8'($urandom), w, p);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule